// File: doc/BRIEF.md
# Floating-Point Status and Trap Register

This block keeps the status word of a floating-point unit and decides when an arithmetic result must raise a floating-point trap. After each operation the datapath presents a 5-bit set of exception indications with a strobe. The block rewrites the flag field from that set, gathers the same bits into a cumulative cause field, and compares the cause field against the trap-enable field. When they overlap it issues a one-cycle trap request that carries a fixed vector code.

Software can load the whole word through a write port. A load also sets two registered control outputs for the arithmetic datapath. One selects round-toward-zero or round-to-nearest-even. The other turns on flushing of denormal operands to zero. The word is 19 bits wide:

| Bits | Field |
|------|-------|
| [1:0] | rounding mode |
| [6:2] | flags |
| [11:7] | trap enables |
| [17:12] | cause (bit 17 is reserved and reads zero) |
| 18 | denormal control |

Exception input bit i maps to flag bit 2+i, cause bit 12+i and enable bit 7+i. Bit 0 is inexact, 1 is underflow, 2 is overflow, 3 is divide-by-zero and 4 is invalid.

Top module: `fpu_status_trap`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `status` is 0, `round_zero` is 1, `flush_zero` is 0, `trap_req` is 0 and `trap_vec` is 0.
- R2: An update (`upd_valid`=1, `wr_en`=0) replaces the flag field [6:2] with `upd_exc`, using the bit mapping above. The result is visible in the next cycle.
- R3: An update with `upd_exc`=0 only clears the flag field. The cause field stays unchanged and no trap request follows.
- R4: An update with nonzero `upd_exc` ORs `upd_exc` into cause bits [16:12], so cause bits accumulate across updates.
- R5: In the cycle after an update with nonzero `upd_exc`, `trap_req` is 1 if and only if the new cause bits [16:12] AND the enables [11:7] are nonzero. `trap_vec` is 0x120 while `trap_req` is 1 and 0 otherwise. `trap_req` is 0 in every other cycle.
- R6: Status bit 17 always reads 0, even after a write that sets it.
- R7: A write (`wr_en`=1) makes `status` equal to `wr_data` with bit 17 cleared in the next cycle, and it raises no trap.
- R8: After a write, `round_zero` is 1 exactly when `wr_data[1:0]` is 00. Updates leave it unchanged.
- R9: After a write, `flush_zero` equals `wr_data[18]`. Updates leave it unchanged.
- R10: When a write and an update arrive in the same cycle, the write takes effect and the update is discarded, including its trap.
- R11: A cause bit that is already set and enabled raises a trap on any later nonzero update, even when the newly reported exceptions are not enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_valid | input | 1 | Exception update strobe |
| upd_exc | input | 5 | Exception indications: [4] invalid, [3] divide-by-zero, [2] overflow, [1] underflow, [0] inexact |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 19 | Register write value |
| status | output | 19 | Current status word |
| round_zero | output | 1 | 1 = round toward zero, 0 = round to nearest even |
| flush_zero | output | 1 | Denormal flush-to-zero enable |
| trap_req | output | 1 | One-cycle trap request |
| trap_vec | output | 12 | Trap vector code, 0x120 during a request |

## Verification
Every result of this block comes out of a single register stage. The status word, both control outputs and the trap pulse therefore all reflect the inputs of the cycle exactly one clock earlier. The bench drives inputs on the falling edge and compares all outputs on the next falling edge against a behavioural model that the same rising edge advanced. No check can fall one cycle early or late. Directed steps cover write priority, the reserved bit, empty updates and traps raised by stale cause bits, and a long random phase mixes writes and updates.

// File: rtl/fpst_pkg.sv
package fpst_pkg;
  localparam int RM_W    = 2;
  localparam int EXC_W   = 5;
  localparam int CAU_W   = EXC_W + 1;
  localparam int FLG_LSB = RM_W;
  localparam int EN_LSB  = FLG_LSB + EXC_W;
  localparam int CAU_LSB = EN_LSB + EXC_W;
  localparam int DN_BIT  = CAU_LSB + CAU_W;
  localparam int STAT_W  = DN_BIT + 1;
  localparam int RSV_BIT = CAU_LSB + CAU_W - 1;
  localparam logic [STAT_W-1:0] WR_MASK = ~(STAT_W'(1) << RSV_BIT);

  typedef struct packed {
    logic             dn;
    logic [CAU_W-1:0] cause;
    logic [EXC_W-1:0] en;
    logic [EXC_W-1:0] flg;
    logic [RM_W-1:0]  rm;
  } stat_t;
endpackage

// File: rtl/fpst_update.sv
module fpst_update
  import fpst_pkg::*;
(
  input  stat_t            cur,
  input  logic [EXC_W-1:0] exc,
  output stat_t            nxt,
  output logic             hit
);
  logic [EXC_W-1:0] merged;

  always_comb begin
    merged = cur.cause[EXC_W-1:0] | exc;
    nxt     = cur;
    nxt.flg = exc;
    hit     = 1'b0;
    if (|exc) begin
      nxt.cause = {1'b0, merged};
      hit       = |(merged & cur.en);
    end
  end
endmodule

// File: rtl/fpst_wr_decode.sv
module fpst_wr_decode
  import fpst_pkg::*;
(
  input  logic [STAT_W-1:0] wdata,
  output stat_t             wval,
  output logic              rz,
  output logic              fz
);
  always_comb begin
    wval = stat_t'(wdata & WR_MASK);
    rz   = (wdata[RM_W-1:0] == '0);
    fz   = wdata[DN_BIT];
  end
endmodule

// File: rtl/fpu_status_trap.sv
module fpu_status_trap
  import fpst_pkg::*;
#(
  parameter int                VEC_W     = 12,
  parameter logic [VEC_W-1:0]  TRAP_CODE = VEC_W'(12'h120)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  logic [EXC_W-1:0]  upd_exc,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] status,
  output logic              round_zero,
  output logic              flush_zero,
  output logic              trap_req,
  output logic [VEC_W-1:0]  trap_vec
);
  stat_t            stat_q, upd_nxt, wr_val;
  logic             hit, wr_rz, wr_fz;
  logic             rz_q, fz_q, trap_q;
  logic [VEC_W-1:0] vec_q;

  fpst_update u_upd (
    .cur (stat_q),
    .exc (upd_exc),
    .nxt (upd_nxt),
    .hit (hit)
  );

  fpst_wr_decode u_wr (
    .wdata (wr_data),
    .wval  (wr_val),
    .rz    (wr_rz),
    .fz    (wr_fz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      rz_q   <= 1'b1;
      fz_q   <= 1'b0;
      trap_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      trap_q <= 1'b0;
      vec_q  <= '0;
      if (wr_en) begin
        stat_q <= wr_val;
        rz_q   <= wr_rz;
        fz_q   <= wr_fz;
      end else if (upd_valid) begin
        stat_q <= upd_nxt;
        if (hit) begin
          trap_q <= 1'b1;
          vec_q  <= TRAP_CODE;
        end
      end
    end
  end

  assign status     = stat_q;
  assign round_zero = rz_q;
  assign flush_zero = fz_q;
  assign trap_req   = trap_q;
  assign trap_vec   = vec_q;
endmodule

// File: rtl/fpst_chk.sv
module fpst_chk
  import fpst_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              upd_valid,
  input logic [EXC_W-1:0]  upd_exc,
  input logic              wr_en,
  input logic [STAT_W-1:0] wr_data,
  input logic [STAT_W-1:0] status,
  input logic              round_zero,
  input logic              flush_zero,
  input logic              trap_req,
  input logic [11:0]       trap_vec
);
  a_r6_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    status[RSV_BIT] == 1'b0);

  a_r5_vec_match: assert property (@(posedge clk) disable iff (rst)
    trap_req == (trap_vec == 12'h120));

  a_r5_trap_cause: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !wr_en && upd_exc == '0) |=> !trap_req);

  a_r10_write_no_trap: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !trap_req);

  a_r7_write_value: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (status[DN_BIT] == $past(wr_data[DN_BIT])) &&
              (status[RSV_BIT-1:0] == $past(wr_data[RSV_BIT-1:0])));

  a_r8_round: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> round_zero == ($past(wr_data[RM_W-1:0]) == '0));

  a_r9_flush: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> flush_zero == $past(wr_data[DN_BIT]));

  a_r3_cause_kept: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !wr_en && upd_exc == '0) |=>
      (status[DN_BIT-1:CAU_LSB] == $past(status[DN_BIT-1:CAU_LSB])));

  a_r2_flags: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !wr_en) |=> status[EN_LSB-1:FLG_LSB] == $past(upd_exc));
endmodule

bind fpu_status_trap fpst_chk u_chk (.*);

// File: tb/tb_fpu_status_trap.sv
module tb_fpu_status_trap;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        upd_valid;
  logic [4:0]  upd_exc;
  logic        wr_en;
  logic [18:0] wr_data;
  logic [18:0] status;
  logic        round_zero, flush_zero, trap_req;
  logic [11:0] trap_vec;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_stat, m_rz, m_fz, m_trap, m_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpu_status_trap dut (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_exc(upd_exc),
    .wr_en(wr_en), .wr_data(wr_data), .status(status),
    .round_zero(round_zero), .flush_zero(flush_zero),
    .trap_req(trap_req), .trap_vec(trap_vec)
  );

  // behavioural reference, advanced on the same edge as the design
  always @(posedge clk) begin
    int en, cz;
    if (rst) begin
      m_stat = 0; m_rz = 1; m_fz = 0; m_trap = 0; m_vec = 0;
    end else begin
      m_trap = 0; m_vec = 0;
      if (wr_en) begin
        m_stat = int'(wr_data) & ~(1 << 17);
        m_rz   = ((int'(wr_data) % 4) == 0) ? 1 : 0;
        m_fz   = (int'(wr_data) >> 18) & 1;
      end else if (upd_valid) begin
        m_stat = (m_stat & ~(31 << 2)) | (int'(upd_exc) << 2);
        if (upd_exc != 0) begin
          m_stat = m_stat | (int'(upd_exc) << 12);
          en = (m_stat >> 7) & 31;
          cz = (m_stat >> 12) & 31;
          if ((en & cz) != 0) begin m_trap = 1; m_vec = 'h120; end
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 flags",  (int'(status) >> 2) & 31,  (m_stat >> 2) & 31);
    chk("R4 cause",  (int'(status) >> 12) & 31, (m_stat >> 12) & 31);
    chk("R6 rsvd",   (int'(status) >> 17) & 1,  0);
    chk("R7 word",   int'(status),              m_stat);
    chk("R8 round",  int'(round_zero),          m_rz);
    chk("R9 flush",  int'(flush_zero),          m_fz);
    chk("R5 trap",   int'(trap_req),            m_trap);
    chk("R5 vector", int'(trap_vec),            m_vec);
  endtask

  task automatic step(bit w, int wd, bit u, int e);
    wr_en = w; wr_data = 19'(wd); upd_valid = u; upd_exc = 5'(e);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; wr_en = 0; wr_data = '0; upd_valid = 0; upd_exc = '0;
    repeat (3) @(negedge clk);
    chk("R1 status", int'(status), 0);
    chk("R1 round", int'(round_zero), 1);
    chk("R1 flush", int'(flush_zero), 0);
    chk("R1 trap", int'(trap_req), 0);
    chk("R1 vector", int'(trap_vec), 0);
    rst = 0;
    step(0, 0, 0, 0);
    chk("R1 after release", int'(status), 0);

    // all enables, rm=1, denormal control on
    step(1, 'h40F81, 0, 0);
    chk("R8 rm=01 gives nearest", int'(round_zero), 0);
    chk("R9 dn=1", int'(flush_zero), 1);
    step(0, 0, 1, 'h01);
    chk("R5 inexact enabled traps", int'(trap_req), 1);
    chk("R5 vector 0x120", int'(trap_vec), 'h120);
    step(0, 0, 1, 'h00);
    chk("R3 empty update no trap", int'(trap_req), 0);
    chk("R3 cause kept", (int'(status) >> 12) & 31, 1);
    chk("R3 flags cleared", (int'(status) >> 2) & 31, 0);
    step(0, 0, 0, 0);
    chk("R5 single-cycle pulse", int'(trap_req), 0);

    // reserved bit written, rm=00, only inexact enabled
    step(1, 'h20080, 0, 0);
    chk("R6 bit17 reads zero", (int'(status) >> 17) & 1, 0);
    chk("R8 rm=00 gives zero", int'(round_zero), 1);
    step(0, 0, 1, 'h02);
    chk("R5 unenabled no trap", int'(trap_req), 0);
    step(0, 0, 1, 'h08);
    chk("R4 cause accumulates", (int'(status) >> 12) & 31, 'h0A);

    // stale enabled cause
    step(1, 'h01080, 0, 0);
    step(0, 0, 1, 'h04);
    chk("R11 stale cause traps", int'(trap_req), 1);

    // write and update together
    step(1, 'h00F80, 1, 'h1F);
    chk("R10 write wins", int'(status), 'h00F80);
    chk("R10 no trap", int'(trap_req), 0);

    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom);
      step(((r & 3) == 0), int'($urandom) & 'h7FFFF, ((r >> 2) & 1) == 1, (r >> 3) & 31);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule